// File: doc/BRIEF.md
# Coalescing Unordered Write Cache

A small, fully associative per-core store buffer for a machine that splits execution into phases. While the core is in its execute phase, the buffer absorbs every store it is given. A store to an address already held is folded into that entry, byte by byte, so each address holds at most one entry carrying the newest bytes. Entries carry no ordering among themselves. Loads from the core can look up the buffer and read back any bytes held for their address.

When the publish phase begins (a one-cycle `flush_start` pulse), the buffer stops taking stores and refuses loads. It then streams every held entry to memory through a valid/ready write port and raises `flush_done` once the last entry has been accepted. After that, the buffer is empty and back in the execute phase.

If a store to a new address arrives while every entry is occupied, the store is dropped and `overflow` is raised. `overflow` stays high until the next flush completes, so that the surrounding control can end the current phase.

Top module: `coalesce_wcache`

## Requirements
- R1: After reset, `overflow`, `mem_valid` and `flush_done` are 0 and no load hits.
- R2: In the execute phase, a store to an address not held takes a free entry. From the next cycle, a load to that address gives `ld_hit`=1, `ld_be` equal to the store's byte mask, and the stored bytes on `ld_data`. Bit i of a byte mask covers data bits [8i+7:8i].
- R3: A store to an address already held merges into the same entry. Each byte whose mask bit is set takes the new value, the other bytes are kept, and the entry's mask becomes the OR of the old and new masks.
- R4: During a flush, each held entry appears on the memory port exactly once, carrying its address, its merged byte mask and its merged data. The order among entries is not specified.
- R5: While `mem_valid` is 1 and `mem_ready` is 0, the next cycle keeps `mem_valid` high with unchanged `mem_addr`, `mem_data` and `mem_be`.
- R6: `flush_done` is high for exactly one cycle, starting in the cycle after the last memory acceptance (or the cycle after `flush_start` if the buffer was empty). `mem_valid` is 0 during that cycle. From the next cycle the buffer is empty and accepts stores again.
- R7: From the cycle after `flush_start` through the `flush_done` cycle, a load gives `ld_refused`=1 and `ld_hit`=0.
- R8: `st_stall` is 1 in the cycle `flush_start` is high and throughout the flush. A store presented while `st_stall` is 1 is not taken.
- R9: A store to a new address while all entries are held is dropped. `overflow` rises in the next cycle and stays high through the `flush_done` cycle, then falls. Stores to held addresses still merge while the buffer is full.
- R10: In the execute phase, a load to an address not held gives `ld_hit`=0 and `ld_refused`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte mask |
| st_stall | output | 1 | Store cannot be taken this cycle |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load address |
| ld_hit | output | 1 | Address held in buffer |
| ld_data | output | DATA_W | Buffered data for the hit |
| ld_be | output | DATA_W/8 | Which bytes of `ld_data` are held |
| ld_refused | output | 1 | Load refused because a flush is in progress |
| flush_start | input | 1 | Start of the publish phase |
| mem_valid | output | 1 | Write to memory offered |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | DATA_W | Write data |
| mem_be | output | DATA_W/8 | Write byte mask |
| overflow | output | 1 | A new-address store found no free entry |
| flush_done | output | 1 | Flush has finished |

## Verification
The bench builds the block with four entries, 32-bit data and 8-bit addresses. Stores are drawn from a pool of only six addresses, so rounds regularly merge into held entries and also overrun the four entries, which exercises coalescing and overflow. `mem_ready` is toggled at random during flushes, so back-pressure holds, empty flushes and back-to-back acceptances all occur. Loads are issued during both phases.

// File: rtl/wcache_pkg.sv
// Package: shared phase type for the coalescing write cache.
// Assumes nothing beyond a two-phase execute/publish scheme.
package wcache_pkg;
    typedef enum logic {
        PH_EXEC  = 1'b0,
        PH_FLUSH = 1'b1
    } phase_t;
endpackage

// File: rtl/wc_match.sv
// wc_match: compares one address against every entry tag.
// Assumes at most one valid tag equals any address (caller keeps tags unique).
module wc_match #(
    parameter int N      = 4,
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [N-1:0][ADDR_W-1:0]  tags,
    input  logic [N-1:0]              valid,
    output logic [N-1:0]              hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        // Per-entry tag compare gated by entry validity.
        assign hit[i] = valid[i] && (tags[i] == addr);
    end
endmodule

// File: rtl/wc_first.sv
// wc_first: returns the index of the lowest set request bit and whether any is set.
// Assumes N >= 2.
module wc_first #(
    parameter int N     = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/wc_phase_fsm.sv
// wc_phase_fsm: tracks execute/publish phase of the write cache.
// Assumes flush_start is ignored once a flush is already running.
module wc_phase_fsm
    import wcache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_start,
    input  logic empty,
    output logic flushing,
    output logic flush_done
);
    phase_t state_q;

    // Phase register: enter flush on start, leave when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_EXEC;
        end else begin
            case (state_q)
                PH_EXEC:  if (flush_start) state_q <= PH_FLUSH;
                PH_FLUSH: if (empty)       state_q <= PH_EXEC;
                default:                   state_q <= PH_EXEC;
            endcase
        end
    end

    // Phase decode for the datapath.
    always_comb begin
        flushing   = (state_q == PH_FLUSH);
        flush_done = flushing && empty;
    end
endmodule

// File: rtl/coalesce_wcache.sv
// coalesce_wcache: fully associative store buffer that merges same-address
// stores by byte mask, serves load lookups, and drains all entries to memory
// on a flush. Assumes DEPTH >= 2 and DATA_W a multiple of 8.
module coalesce_wcache #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    output logic              st_stall,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic [BE_W-1:0]   ld_be,
    output logic              ld_refused,
    input  logic              flush_start,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [BE_W-1:0]   mem_be,
    output logic              overflow,
    output logic              flush_done
);
    logic [DEPTH-1:0]             valid_q;
    logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
    logic [DEPTH-1:0][DATA_W-1:0] data_q;
    logic [DEPTH-1:0][BE_W-1:0]   be_q;
    logic                         ovf_q;

    logic [DEPTH-1:0] st_hit_vec, ld_hit_vec;
    logic [IDX_W-1:0] st_idx, ld_idx, free_idx, out_idx;
    logic             st_any, ld_any, free_any, out_any;
    logic             flushing, st_take;

    wc_match #(.N(DEPTH), .ADDR_W(ADDR_W)) u_st_match (
        .addr(st_addr), .tags(addr_q), .valid(valid_q), .hit(st_hit_vec));
    wc_match #(.N(DEPTH), .ADDR_W(ADDR_W)) u_ld_match (
        .addr(ld_addr), .tags(addr_q), .valid(valid_q), .hit(ld_hit_vec));

    wc_first #(.N(DEPTH)) u_st_pick   (.req(st_hit_vec), .idx(st_idx),   .any(st_any));
    wc_first #(.N(DEPTH)) u_ld_pick   (.req(ld_hit_vec), .idx(ld_idx),   .any(ld_any));
    wc_first #(.N(DEPTH)) u_free_pick (.req(~valid_q),   .idx(free_idx), .any(free_any));
    wc_first #(.N(DEPTH)) u_out_pick  (.req(valid_q),    .idx(out_idx),  .any(out_any));

    wc_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .flush_start(flush_start),
        .empty(!out_any), .flushing(flushing), .flush_done(flush_done));

    // Store admission: blocked at the phase boundary and during the flush.
    always_comb begin
        st_stall = flushing || flush_start;
        st_take  = st_valid && !st_stall;
    end

    // Load lookup: refused during flush, otherwise served from the entry array.
    always_comb begin
        ld_refused = ld_valid && flushing;
        ld_hit     = ld_valid && !flushing && ld_any;
        ld_data    = ld_hit ? data_q[ld_idx] : '0;
        ld_be      = ld_hit ? be_q[ld_idx]   : '0;
    end

    // Memory write port: offer the lowest held entry while flushing.
    always_comb begin
        mem_valid = flushing && out_any;
        mem_addr  = addr_q[out_idx];
        mem_data  = data_q[out_idx];
        mem_be    = be_q[out_idx];
        overflow  = ovf_q;
    end

    // Entry array update: merge, allocate, flag overflow, retire on drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (flush_done) begin
                ovf_q <= 1'b0;
            end else if (st_take) begin
                if (st_any) begin
                    for (int b = 0; b < BE_W; b++) begin
                        if (st_be[b]) data_q[st_idx][b*8 +: 8] <= st_data[b*8 +: 8];
                    end
                    be_q[st_idx] <= be_q[st_idx] | st_be;
                end else if (free_any) begin
                    valid_q[free_idx] <= 1'b1;
                    addr_q[free_idx]  <= st_addr;
                    data_q[free_idx]  <= st_data;
                    be_q[free_idx]    <= st_be;
                end else begin
                    ovf_q <= 1'b1;
                end
            end
            if (mem_valid && mem_ready) valid_q[out_idx] <= 1'b0;
        end
    end
endmodule

// File: rtl/wcache_checker.sv
// wcache_checker: port-level properties of coalesce_wcache, bound to the top.
// Assumes synchronous active-low reset.
module wcache_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_stall,
    input logic              ld_hit,
    input logic              ld_refused,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic [BE_W-1:0]   mem_be,
    input logic              overflow,
    input logic              flush_done
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> !mem_valid); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done); // R6
    AST_EMPTY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !ld_hit); // R6
    AST_REFUSE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_refused |-> !ld_hit); // R7
    AST_DRAIN_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || flush_done) |-> st_stall); // R8
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !flush_done |=> overflow); // R9
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !overflow); // R9
endmodule

bind coalesce_wcache wcache_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wcache_chk (
    .clk(clk), .rst_n(rst_n), .st_stall(st_stall), .ld_hit(ld_hit),
    .ld_refused(ld_refused), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .overflow(overflow), .flush_done(flush_done));

// File: tb/coalesce_wcache_bench.sv
// Bench for coalesce_wcache: directed corners plus seeded random rounds,
// checked against an order-free model of the buffer contents.
module coalesce_wcache_bench;
    localparam int AW = 8, DW = 32, DEP = 4, BW = DW / 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic st_valid = 0, ld_valid = 0, flush_start = 0, mem_ready = 0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [BW-1:0] st_be = '0;
    logic st_stall, ld_hit, ld_refused, mem_valid, overflow, flush_done;
    logic [DW-1:0] ld_data, mem_data;
    logic [BW-1:0] ld_be, mem_be;
    logic [AW-1:0] mem_addr;

    int total = 0, bad = 0;

    logic [AW-1:0] m_addr [DEP];
    logic [DW-1:0] m_data [DEP];
    logic [BW-1:0] m_be   [DEP];
    logic          m_val  [DEP];
    logic          m_seen [DEP];
    logic          exp_ovf = 0;

    coalesce_wcache #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP)) u_coalesce_wcache (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_stall(st_stall),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit),
        .ld_data(ld_data), .ld_be(ld_be), .ld_refused(ld_refused),
        .flush_start(flush_start), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
        .overflow(overflow), .flush_done(flush_done));

    always #2.5 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mask_of(input logic [BW-1:0] be);
        logic [DW-1:0] m;
        for (int b = 0; b < BW; b++) m[b*8 +: 8] = be[b] ? 8'hFF : 8'h00;
        return m;
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < DEP; i++) begin m_val[i] = 0; m_seen[i] = 0; end
        exp_ovf = 0;
    endfunction

    function automatic void model_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be);
        logic [DW-1:0] mk;
        mk = mask_of(be);
        for (int i = 0; i < DEP; i++) begin
            if (m_val[i] && m_addr[i] == a) begin
                m_data[i] = (m_data[i] & ~mk) | (d & mk);
                m_be[i]   = m_be[i] | be;
                return;
            end
        end
        for (int i = 0; i < DEP; i++) begin
            if (!m_val[i]) begin
                m_val[i] = 1; m_addr[i] = a; m_data[i] = d & mk; m_be[i] = be;
                return;
            end
        end
        exp_ovf = 1;
    endfunction

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be);
        @(negedge clk);
        st_valid = 1; st_addr = a; st_data = d; st_be = be;
        #1 check(st_stall == 0, "R8 stall in execute", st_stall, 0);
        @(posedge clk);
        model_store(a, d, be);
        #1 st_valid = 0;
        @(negedge clk);
        #1 check(overflow == exp_ovf, "R9 overflow flag", overflow, exp_ovf);
    endtask

    task automatic do_load(input logic [AW-1:0] a);
        int k;
        k = -1;
        for (int i = 0; i < DEP; i++) if (m_val[i] && m_addr[i] == a) k = i;
        @(negedge clk);
        ld_valid = 1; ld_addr = a;
        #1;
        if (k < 0) begin
            check(ld_hit == 0 && ld_refused == 0, "R10 miss", {ld_hit, ld_refused}, 0);
        end else begin
            check(ld_hit == 1, "R2 load hit", ld_hit, 1);
            check(ld_be == m_be[k], "R3 merged mask", ld_be, m_be[k]);
            check((ld_data & mask_of(m_be[k])) == m_data[k], "R3 merged data",
                  ld_data & mask_of(m_be[k]), m_data[k]);
        end
        ld_valid = 0;
    endtask

    task automatic do_flush();
        int cyc, k;
        bit pend;
        logic [AW-1:0] pa; logic [DW-1:0] pd; logic [BW-1:0] pb;
        pend = 0; cyc = 0;
        @(negedge clk);
        flush_start = 1;
        st_valid = 1; st_addr = 8'hFE; st_data = 32'hDEAD_BEEF; st_be = '1;
        #1 check(st_stall == 1, "R8 stall at flush start", st_stall, 1);
        @(posedge clk);
        #1 flush_start = 0;
        forever begin
            @(negedge clk);
            mem_ready = 1'($urandom % 2);
            ld_valid = 1; ld_addr = m_addr[0];
            #1;
            check(ld_refused == 1 && ld_hit == 0, "R7 load refused in flush", {ld_refused, ld_hit}, 2'b10);
            check(st_stall == 1, "R8 stall in flush", st_stall, 1);
            check(overflow == exp_ovf, "R9 overflow held in flush", overflow, exp_ovf);
            if (pend) check(mem_valid && mem_addr == pa && mem_data == pd && mem_be == pb,
                            "R5 held under backpressure", mem_addr, pa);
            if (flush_done) begin
                check(mem_valid == 0, "R6 quiet at done", mem_valid, 0);
                break;
            end
            pend = 0;
            if (mem_valid) begin
                k = -1;
                for (int i = 0; i < DEP; i++) if (m_val[i] && !m_seen[i] && m_addr[i] == mem_addr) k = i;
                check(k >= 0, "R4 write matches a held entry", mem_addr, 0);
                if (k >= 0) begin
                    check(mem_be == m_be[k] && (mem_data & mask_of(m_be[k])) == m_data[k],
                          "R4 write contents", mem_data & mask_of(mem_be), m_data[k]);
                    if (mem_ready) m_seen[k] = 1;
                end
                if (!mem_ready) begin pend = 1; pa = mem_addr; pd = mem_data; pb = mem_be; end
            end
            cyc++;
            if (cyc > 200) begin check(0, "R6 flush finishes", cyc, 0); break; end
        end
        for (int i = 0; i < DEP; i++)
            if (m_val[i]) check(m_seen[i] == 1, "R4 every entry written once", m_seen[i], 1);
        @(posedge clk);
        #1 ld_valid = 0; st_valid = 0; mem_ready = 0;
        model_clear();
        @(negedge clk);
        #1 check(overflow == 0, "R9 overflow cleared after done", overflow, 0);
        check(st_stall == 0, "R6 stores accepted after done", st_stall, 0);
        do_load(8'hFE);
        do_load(8'h01);
    endtask

    initial begin
        process::self().srandom(32'h5EED_1234);
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(overflow == 0 && mem_valid == 0 && flush_done == 0, "R1 reset outputs",
              {overflow, mem_valid, flush_done}, 0);
        ld_valid = 1; ld_addr = 8'h00;
        #1 check(ld_hit == 0, "R1 no hit after reset", ld_hit, 0);
        ld_valid = 0;

        // R2 / R3: directed allocate then byte merge.
        do_store(8'h10, 32'h1111_1111, 4'b0011);
        do_load(8'h10);
        do_store(8'h10, 32'h2222_2222, 4'b1100);
        do_load(8'h10);
        do_store(8'h10, 32'h3333_3333, 4'b0100);
        do_load(8'h10);
        do_load(8'h11);
        do_flush();

        // R6: flush with nothing held.
        do_flush();

        // R9: fill, overrun, then merge while full.
        for (int i = 0; i < DEP; i++) do_store(AW'(8'h20 + i), 32'hA0A0_0000 + i, 4'b1111);
        do_store(8'h30, 32'hBAD0_0000, 4'b1111);
        do_load(8'h30);
        do_store(8'h21, 32'h5555_5555, 4'b0001);
        do_load(8'h21);
        do_flush();

        // Random rounds over a small address pool.
        for (int r = 0; r < 30; r++) begin
            int n;
            n = 1 + ($urandom % 9);
            for (int s = 0; s < n; s++) begin
                logic [BW-1:0] be;
                be = BW'($urandom);
                if (be == 0) be = 4'b0001;
                do_store(AW'($urandom % 6), $urandom, be);
                if ($urandom % 2) do_load(AW'($urandom % 7));
            end
            do_flush();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule